// File: doc/BRIEF.md
# Dual Two-Level Command Chaining Queue

This block sits between a host and a pair of packet engines (one that sends, one that receives). The host writes transmit and receive commands; each direction keeps its own short queue of pending commands, and the head of each queue is offered to its engine, which takes it when it starts work. When an engine finishes a packet it pulses a completion strobe with a few status bits. Those completions are queued per direction, so the host can service them late without losing any.

Each direction holds two commands and two completion entries when chaining is switched on. With chaining off, which is the state after reset, every queue acts as a single slot and a newer write replaces the older one. The host reads a packed status word that shows, per direction, whether a completion is pending and the status bits of the oldest one. It also shows a sticky overflow flag. Clearing a direction's interrupt retires that oldest completion. The interrupt output is the OR of the pending bits, each gated by its own mask input.

Top module: `cmdchain_queue`

## Requirements
- R1: After reset both command queues and both completion queues are empty, `statusWord` is 0, `irq` is 0, and both `txCmdValid` and `rxCmdValid` are 0.
- R2: With `chainEn`=1, each direction accepts two commands (`cmdRx`=0 selects transmit, 1 selects receive). They are offered on `txCmdArg`/`rxCmdArg` oldest first, and writes to one direction never disturb the other. An offered argument reads 0 while its valid bit is 0.
- R3: With `chainEn`=1, a command written to a queue that already holds two entries, with no take in that cycle, is dropped. The overflow bit `statusWord[2]` then goes to 1 and stays at 1 until reset.
- R4: With `chainEn`=0, a command written while one is pending replaces it. Only one command is ever pending per direction, and a command write never sets the overflow bit.
- R5: A completion pulse (`txDone`/`rxDone`) stores its status bits. The pending bit (`statusWord[0]` transmit, `statusWord[1]` receive) rises only on the edge after a completion pulse. The head status field (`statusWord[4:3]` transmit, `statusWord[6:5]` receive) shows the oldest stored status and reads 0 when nothing is pending.
- R6: A clear (`txIntClr`/`rxIntClr`) while a completion is pending retires the oldest entry. The field then shows the next entry, or the pending bit drops if none is left.
- R7: `irq` is 1 exactly when (`statusWord[0]` and `txMask`) or (`statusWord[1]` and `rxMask`).
- R8: With `chainEn`=1, a completion arriving when two are already stored, with no clear in that cycle, is dropped and sets the overflow bit. With `chainEn`=0, a new completion replaces the stored one.
- R9: An engine take (`txTake`/`rxTake`) while its command is valid removes the head. The next queued command becomes visible on the following cycle. If the queue is full, a write in the same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chainEn | input | 1 | Chaining enable, bit 6 of the host configuration register |
| cmdWr | input | 1 | Host command write strobe |
| cmdRx | input | 1 | Command direction: 0 transmit, 1 receive |
| cmdArg | input | CMD_W | Command argument (buffer page) |
| txTake | input | 1 | Transmit engine consumes the head command |
| rxTake | input | 1 | Receive engine consumes the head command |
| txCmdValid | output | 1 | A transmit command is pending |
| txCmdArg | output | CMD_W | Oldest pending transmit argument |
| rxCmdValid | output | 1 | A receive command is pending |
| rxCmdArg | output | CMD_W | Oldest pending receive argument |
| txDone | input | 1 | Transmit completion pulse |
| txStat | input | STAT_W | Status bits of the transmit completion |
| rxDone | input | 1 | Receive completion pulse |
| rxStat | input | STAT_W | Status bits of the receive completion |
| txIntClr | input | 1 | Host clears the transmit completion at the head |
| rxIntClr | input | 1 | Host clears the receive completion at the head |
| txMask | input | 1 | Transmit interrupt mask (1 enables) |
| rxMask | input | 1 | Receive interrupt mask (1 enables) |
| statusWord | output | 3+2*STAT_W | {rx head status, tx head status, overflow, rx pending, tx pending} |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that `chainEn` changes only while every queue is empty. Without that, a queue holding two entries would be read in single-slot mode. They also assume completion and clear strobes are single-cycle pulses sampled on the rising edge. The bench follows both rules: it asserts reset before each change of mode and keeps the mode fixed for a whole phase. Within a phase, random writes, takes, completions and clears may land on any cycle and in any combination. This includes a write and a take on a full queue in the same cycle.

// File: rtl/cmdchain_pkg.sv
package cmdchain_pkg;
  // Index 0 is the transmit direction, index 1 the receive direction.
  typedef struct packed {
    logic [1:0] cmdPush;
    logic [1:0] cmdPop;
    logic [1:0] cmdRepl;
    logic [1:0] stPush;
    logic [1:0] stPop;
    logic [1:0] stRepl;
  } qStrobe_t;
endpackage

// File: rtl/cmdchain_q2.sv
module cmdchain_q2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic         repl,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic [1:0]   count
);
  logic [W-1:0] slot0, slot1;
  logic [1:0]   cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot0 <= '0;
      slot1 <= '0;
      cnt   <= 2'd0;
    end else if (repl) begin
      slot0 <= din;
    end else begin
      case ({push, pop})
        2'b10: begin
          if (cnt == 2'd0) slot0 <= din;
          else             slot1 <= din;
          cnt <= cnt + 2'd1;
        end
        2'b01: begin
          slot0 <= slot1;
          cnt   <= cnt - 2'd1;
        end
        2'b11: begin
          if (cnt == 2'd1) slot0 <= din;
          else begin
            slot0 <= slot1;
            slot1 <= din;
          end
        end
        default: ;
      endcase
    end
  end

  assign head  = slot0;
  assign count = cnt;
endmodule

// File: rtl/cmdchain_dp.sv
module cmdchain_dp import cmdchain_pkg::*; #(
  parameter int CMD_W  = 4,
  parameter int STAT_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  qStrobe_t               stb,
  input  logic [CMD_W-1:0]       cmdArg,
  input  logic [1:0][STAT_W-1:0] statIn,
  output logic [1:0][CMD_W-1:0]  cmdHead,
  output logic [1:0][1:0]        cmdCnt,
  output logic [1:0][STAT_W-1:0] stHead,
  output logic [1:0][1:0]        stCnt
);
  for (genvar d = 0; d < 2; d++) begin : g_dir
    cmdchain_q2 #(.W(CMD_W)) u_cmdQ (
      .clk(clk), .rstN(rstN),
      .push(stb.cmdPush[d]), .pop(stb.cmdPop[d]), .repl(stb.cmdRepl[d]),
      .din(cmdArg), .head(cmdHead[d]), .count(cmdCnt[d])
    );
    cmdchain_q2 #(.W(STAT_W)) u_statQ (
      .clk(clk), .rstN(rstN),
      .push(stb.stPush[d]), .pop(stb.stPop[d]), .repl(stb.stRepl[d]),
      .din(statIn[d]), .head(stHead[d]), .count(stCnt[d])
    );
  end
endmodule

// File: rtl/cmdchain_ctl.sv
module cmdchain_ctl import cmdchain_pkg::*; (
  input  logic            clk,
  input  logic            rstN,
  input  logic            chainEn,
  input  logic            cmdWr,
  input  logic            cmdRx,
  input  logic [1:0]      take,
  input  logic [1:0]      done,
  input  logic [1:0]      clr,
  input  logic [1:0][1:0] cmdCnt,
  input  logic [1:0][1:0] stCnt,
  output qStrobe_t        stb,
  output logic            ovf
);
  // Returns {push, replace, overflow} for one queue.
  function automatic logic [2:0] decide(input logic req, input logic popOk,
                                        input logic [1:0] cnt, input logic chain);
    logic [2:0] r;
    r = 3'b000;
    if (req) begin
      if (chain) begin
        if (cnt != 2'd2 || popOk) r = 3'b100;
        else                      r = 3'b001;
      end else begin
        if (cnt != 2'd0 && !popOk) r = 3'b010;
        else                       r = 3'b100;
      end
    end
    return r;
  endfunction

  logic overHit;

  always_comb begin
    logic [2:0] cDec, sDec;
    logic       cPop, sPop, wrHere;
    stb     = '0;
    overHit = 1'b0;
    for (int d = 0; d < 2; d++) begin
      wrHere = cmdWr && (cmdRx == d[0]);
      cPop   = take[d] && (cmdCnt[d] != 2'd0);
      sPop   = clr[d]  && (stCnt[d]  != 2'd0);
      cDec   = decide(wrHere,  cPop, cmdCnt[d], chainEn);
      sDec   = decide(done[d], sPop, stCnt[d],  chainEn);
      stb.cmdPush[d] = cDec[2];
      stb.cmdRepl[d] = cDec[1];
      stb.cmdPop[d]  = cPop;
      stb.stPush[d]  = sDec[2];
      stb.stRepl[d]  = sDec[1];
      stb.stPop[d]   = sPop;
      overHit = overHit | cDec[0] | sDec[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        ovf <= 1'b0;
    else if (overHit) ovf <= 1'b1;
  end
endmodule

// File: rtl/cmdchain_queue.sv
module cmdchain_queue import cmdchain_pkg::*; #(
  parameter int CMD_W  = 4,
  parameter int STAT_W = 2,
  localparam int SW_W  = 3 + 2 * STAT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chainEn,
  input  logic              cmdWr,
  input  logic              cmdRx,
  input  logic [CMD_W-1:0]  cmdArg,
  input  logic              txTake,
  input  logic              rxTake,
  output logic              txCmdValid,
  output logic [CMD_W-1:0]  txCmdArg,
  output logic              rxCmdValid,
  output logic [CMD_W-1:0]  rxCmdArg,
  input  logic              txDone,
  input  logic [STAT_W-1:0] txStat,
  input  logic              rxDone,
  input  logic [STAT_W-1:0] rxStat,
  input  logic              txIntClr,
  input  logic              rxIntClr,
  input  logic              txMask,
  input  logic              rxMask,
  output logic [SW_W-1:0]   statusWord,
  output logic              irq
);
  qStrobe_t               stb;
  logic                   ovf;
  logic [1:0][CMD_W-1:0]  cmdHead;
  logic [1:0][1:0]        cmdCnt, stCnt;
  logic [1:0][STAT_W-1:0] stHead;
  logic                   txPend, rxPend;

  cmdchain_ctl u_ctl (
    .clk(clk), .rstN(rstN), .chainEn(chainEn),
    .cmdWr(cmdWr), .cmdRx(cmdRx),
    .take({rxTake, txTake}), .done({rxDone, txDone}), .clr({rxIntClr, txIntClr}),
    .cmdCnt(cmdCnt), .stCnt(stCnt), .stb(stb), .ovf(ovf)
  );

  cmdchain_dp #(.CMD_W(CMD_W), .STAT_W(STAT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdArg(cmdArg),
    .statIn({rxStat, txStat}),
    .cmdHead(cmdHead), .cmdCnt(cmdCnt), .stHead(stHead), .stCnt(stCnt)
  );

  assign txCmdValid = (cmdCnt[0] != 2'd0);
  assign rxCmdValid = (cmdCnt[1] != 2'd0);
  assign txCmdArg   = txCmdValid ? cmdHead[0] : '0;
  assign rxCmdArg   = rxCmdValid ? cmdHead[1] : '0;
  assign txPend     = (stCnt[0] != 2'd0);
  assign rxPend     = (stCnt[1] != 2'd0);
  assign statusWord = {rxPend ? stHead[1] : {STAT_W{1'b0}},
                       txPend ? stHead[0] : {STAT_W{1'b0}},
                       ovf, rxPend, txPend};
  assign irq        = (txPend & txMask) | (rxPend & rxMask);
endmodule

// File: rtl/cmdchain_queue_chk.sv
module cmdchain_queue_chk #(
  parameter int STAT_W = 2,
  localparam int SW_W  = 3 + 2 * STAT_W
) (
  input logic            clk,
  input logic            rstN,
  input logic            chainEn,
  input logic            cmdWr,
  input logic            txDone,
  input logic            rxDone,
  input logic            txMask,
  input logic            rxMask,
  input logic            txCmdValid,
  input logic            rxCmdValid,
  input logic [SW_W-1:0] statusWord,
  input logic            irq
);
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[2] |=> statusWord[2]);

  assert_tx_pend_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWord[0] && !txDone) |=> !statusWord[0]);

  assert_rx_pend_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWord[1] && !rxDone) |=> !statusWord[1]);

  assert_single_no_ovf_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!chainEn && !statusWord[2] && !txDone && !rxDone) |=> !statusWord[2]);

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq == ((statusWord[0] && txMask) || (statusWord[1] && rxMask)));

  assert_idle_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdWr && !txCmdValid) |=> !txCmdValid);

  assert_idle_rxcmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdWr && !rxCmdValid) |=> !rxCmdValid);
endmodule

bind cmdchain_queue cmdchain_queue_chk #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rstN(rstN), .chainEn(chainEn), .cmdWr(cmdWr),
  .txDone(txDone), .rxDone(rxDone), .txMask(txMask), .rxMask(rxMask),
  .txCmdValid(txCmdValid), .rxCmdValid(rxCmdValid),
  .statusWord(statusWord), .irq(irq)
);

// File: tb/cmdchain_queue_bench.sv
module cmdchain_queue_bench;
  localparam int CW = 4;
  localparam int SW = 2;
  localparam int WW = 3 + 2 * SW;

  logic clk = 1'b0, rstN = 1'b0, chainEn = 1'b0;
  logic cmdWr = 1'b0, cmdRx = 1'b0, txTake = 1'b0, rxTake = 1'b0;
  logic [CW-1:0] cmdArg = '0;
  logic txDone = 1'b0, rxDone = 1'b0, txIntClr = 1'b0, rxIntClr = 1'b0;
  logic [SW-1:0] txStat = '0, rxStat = '0;
  logic txMask = 1'b0, rxMask = 1'b0;
  logic txCmdValid, rxCmdValid, irq;
  logic [CW-1:0] txCmdArg, rxCmdArg;
  logic [WW-1:0] statusWord;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  int mc[2][2], mcN[2], ms[2][2], msN[2];
  bit mOvf;

  always #10 clk = ~clk;

  cmdchain_queue #(.CMD_W(CW), .STAT_W(SW)) u_cmdchain_queue (
    .clk(clk), .rstN(rstN), .chainEn(chainEn), .cmdWr(cmdWr), .cmdRx(cmdRx),
    .cmdArg(cmdArg), .txTake(txTake), .rxTake(rxTake),
    .txCmdValid(txCmdValid), .txCmdArg(txCmdArg),
    .rxCmdValid(rxCmdValid), .rxCmdArg(rxCmdArg),
    .txDone(txDone), .txStat(txStat), .rxDone(rxDone), .rxStat(rxStat),
    .txIntClr(txIntClr), .rxIntClr(rxIntClr), .txMask(txMask), .rxMask(rxMask),
    .statusWord(statusWord), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int d = 0; d < 2; d++) begin
      mcN[d] = 0; msN[d] = 0;
      for (int k = 0; k < 2; k++) begin mc[d][k] = 0; ms[d][k] = 0; end
    end
    mOvf = 1'b0;
  endtask

  task automatic doReset(input bit chain);
    rstN = 1'b0;
    chainEn = chain;
    modelReset();
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  // One queue step of the model: retire head first, then place the new entry.
  task automatic modelQ(input bit isStat, input int d, input bit req, input int val,
                        input bit rem, input bit chain);
    int n;
    n = isStat ? msN[d] : mcN[d];
    if (rem && n > 0) begin
      if (isStat) ms[d][0] = ms[d][1]; else mc[d][0] = mc[d][1];
      n--;
    end
    if (req) begin
      if (chain && n == 2) mOvf = 1'b1;
      else if (!chain && n == 1) begin
        if (isStat) ms[d][0] = val; else mc[d][0] = val;
      end else begin
        if (isStat) ms[d][n] = val; else mc[d][n] = val;
        n++;
      end
    end
    if (isStat) msN[d] = n; else mcN[d] = n;
  endtask

  task automatic compareAll(input string tag);
    int expSw;
    expSw = (msN[0] > 0 ? 1 : 0) | ((msN[1] > 0 ? 1 : 0) << 1) | (int'(mOvf) << 2)
          | ((msN[0] > 0 ? ms[0][0] : 0) << 3) | ((msN[1] > 0 ? ms[1][0] : 0) << (3 + SW));
    chk({tag, " statusWord"}, int'(statusWord), expSw);
    chk({tag, " txCmd"}, {txCmdValid, txCmdArg}, ((mcN[0] > 0) << CW) | (mcN[0] > 0 ? mc[0][0] : 0));
    chk({tag, " rxCmd"}, {rxCmdValid, rxCmdArg}, ((mcN[1] > 0) << CW) | (mcN[1] > 0 ? mc[1][0] : 0));
    chk({tag, " irq R7"}, int'(irq),
        int'(((msN[0] > 0) && txMask) || ((msN[1] > 0) && rxMask)));
  endtask

  task automatic step(input string tag, input bit wr, input bit rxSel, input int arg,
                      input bit tkT, input bit tkR, input bit dnT, input bit dnR,
                      input int sT, input int sR, input bit clT, input bit clR);
    cmdWr = wr; cmdRx = rxSel; cmdArg = CW'(arg);
    txTake = tkT; rxTake = tkR; txDone = dnT; rxDone = dnR;
    txStat = SW'(sT); rxStat = SW'(sR); txIntClr = clT; rxIntClr = clR;
    modelQ(1'b0, 0, wr && !rxSel, arg, tkT, chainEn);
    modelQ(1'b0, 1, wr && rxSel,  arg, tkR, chainEn);
    modelQ(1'b1, 0, dnT, sT, clT, chainEn);
    modelQ(1'b1, 1, dnR, sR, clR, chainEn);
    @(posedge clk);
    #1;
    cmdWr = 0; txTake = 0; rxTake = 0; txDone = 0; rxDone = 0; txIntClr = 0; rxIntClr = 0;
    compareAll(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    // R1: reset state
    doReset(1'b0);
    #1;
    chk("R1 statusWord", int'(statusWord), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 cmd valids", int'({txCmdValid, rxCmdValid}), 0);

    // Chaining mode, directed
    doReset(1'b1);
    step("R2 wr tx5", 1, 0, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2 wr rx9", 1, 1, 9, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2 wr tx7", 1, 0, 7, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 tx head oldest", int'(txCmdArg), 5);
    chk("R2 rx independent", int'(rxCmdArg), 9);
    chk("R3 no ovf yet", int'(statusWord[2]), 0);
    step("R3 wr tx3 full", 1, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 ovf set", int'(statusWord[2]), 1);
    step("R9 take tx", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 next head", int'(txCmdArg), 7);
    step("R9 take tx+wr", 1, 0, 11, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 accepted with take", int'(txCmdArg), 11);
    step("R3 take tx", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 dropped cmd absent", int'(txCmdValid), 0);
    chk("R3 ovf sticky", int'(statusWord[2]), 1);

    doReset(1'b1);
    idle("R5 idle");
    chk("R5 no pend without done", int'(statusWord[1:0]), 0);
    step("R5 done tx1", 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0);
    chk("R5 tx pend", int'(statusWord[0]), 1);
    chk("R5 tx head stat", int'(statusWord[4:3]), 1);
    step("R5 done tx2 rx3", 0, 0, 0, 0, 0, 1, 1, 2, 3, 0, 0);
    chk("R7 masked off", int'(irq), 0);
    txMask = 1'b1; #1;
    chk("R7 tx mask on", int'(irq), 1);
    txMask = 1'b0; rxMask = 1'b1; #1;
    chk("R7 rx mask on", int'(irq), 1);
    rxMask = 1'b0;
    step("R6 clr tx", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R6 next tx stat", int'(statusWord[4:3]), 2);
    step("R8 done tx full", 0, 0, 0, 0, 0, 1, 0, 3, 0, 0, 0);
    step("R8 done tx over", 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0);
    chk("R8 ovf on full status", int'(statusWord[2]), 1);
    step("R6 clr tx", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 dropped stat absent", int'(statusWord[4:3]), 3);
    step("R6 clr tx last", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R6 tx pend gone", int'(statusWord[0]), 0);
    chk("R6 rx untouched", int'(statusWord[6:5]), 3);

    // Single-slot mode, directed
    doReset(1'b0);
    step("R4 wr tx4", 1, 0, 4, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R4 wr tx6", 1, 0, 6, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 replaced", int'(txCmdArg), 6);
    step("R4 wr tx8", 1, 0, 8, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 no ovf", int'(statusWord[2]), 0);
    step("R4 take", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 single entry", int'(txCmdValid), 0);
    step("R8 s done rx1", 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0);
    step("R8 s done rx2", 0, 0, 0, 0, 0, 0, 1, 0, 2, 0, 0);
    chk("R8 single replaced", int'(statusWord[6:5]), 2);
    step("R8 s clr rx", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 single slot empty", int'(statusWord[1]), 0);

    // Random sweep in both modes (R2 R3 R4 R5 R6 R8 R9)
    for (int mode = 0; mode < 2; mode++) begin
      doReset(mode[0]);
      for (int i = 0; i < 4000; i++) begin
        int r;
        r = $urandom;
        txMask = r[20]; rxMask = r[21];
        step("R2 R9 R6 sweep", r[2:0] < 3, r[3], int'(r[7:4]),
             r[9:8] == 0, r[11:10] == 0, r[13:12] == 0, r[15:14] == 0,
             int'(r[17:16]), int'(r[19:18]),
             r[24:22] < 2, r[27:25] < 2);
      end
    end

    finished = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule